// File: doc/BRIEF.md
# Interface Mode Switch Controller

This block chooses whether a flash device's I/O logic runs its asynchronous interface or its synchronous double-data-rate (DDR) interface. It watches the command, address and data cycles that the host presents on a shared byte bus. It recognises one set-feature sequence: an opcode cycle, one feature-address cycle and a fixed number of parameter cycles. If that sequence targets the interface-configuration feature, the block starts a timed changeover.

For the whole changeover the block holds `busy` high and ignores all bus traffic. The interface select output `ddr_sel` takes its new value on the same clock edge that drops `busy`, so the I/O logic never sees the select move mid-interval. The length of the interval comes from a count of clock cycles that the surrounding logic supplies. The block always leaves reset in asynchronous mode. After that it can switch in either direction as often as the host asks.

Top module: `ifsel_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `ddr_sel` is 0 (asynchronous) and `busy` is 0. A reset during a changeover aborts it.
- R2: A sequence counts only if it begins with a command cycle carrying 0xEF. Address and parameter cycles that follow any other command byte change nothing.
- R3: Switching works in both directions: DDR to asynchronous as well as asynchronous to DDR.
- R4: `busy` rises on the edge that captures the fourth parameter cycle. `itc_cycles` is sampled on that same edge, and later changes to it do not affect the running interval.
- R5: Only bit 0 of parameter byte zero selects the new interface (1 = DDR, 0 = asynchronous). The other bits and the other three parameter bytes are ignored.
- R6: `busy` stays high for exactly the sampled number of clock cycles. `ddr_sel` holds its old value throughout and changes only on the edge where `busy` falls.
- R7: A sequence whose feature address is not 0x10 is accepted and then discarded. It raises no `busy` and leaves `ddr_sel` unchanged.
- R8: Every command, address and data cycle presented while `busy` is high is ignored.
- R9: A sampled interval count of 0 is treated as 1 cycle.
- R10: A new 0xEF command cycle in the middle of a sequence discards the partial sequence and starts a fresh one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Bus byte is a command cycle |
| addr_we | input | 1 | Bus byte is an address cycle |
| data_we | input | 1 | Bus byte is a parameter (data) cycle |
| bus_in | input | 8 | Shared command/address/data byte |
| itc_cycles | input | CNT_W | Changeover interval length in clock cycles |
| ddr_sel | output | 1 | Interface select: 1 = DDR, 0 = asynchronous |
| busy | output | 1 | High during the changeover interval |

## Verification
Four properties are checked on every cycle:
- both outputs come out of reset clear;
- `busy` only ever begins right after a parameter cycle;
- `ddr_sel` stays frozen while `busy` is held;
- any movement of `ddr_sel` coincides with the fall of `busy`.

Some behaviour can only be shown by the directed scenarios:
- the exact length of each interval;
- that bus traffic during `busy` is dropped;
- which opcodes, addresses and parameter bits matter;
- how a restarted sequence is handled;
- that a zero count gives one cycle.

// File: rtl/ifsel_ctrl.sv
module ifsel_ctrl #(
  parameter logic [7:0] SET_FEAT_OP  = 8'hEF,
  parameter logic [7:0] IF_FEAT_ADDR = 8'h10,
  parameter int         PARAM_BYTES  = 4,
  parameter int         CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             addr_we,
  input  logic             data_we,
  input  logic [7:0]       bus_in,
  input  logic [CNT_W-1:0] itc_cycles,
  output logic             ddr_sel,
  output logic             busy
);
  localparam int PC_W = (PARAM_BYTES > 1) ? $clog2(PARAM_BYTES) : 1;
  localparam logic [PC_W-1:0] LAST_IDX = PC_W'(PARAM_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_PARAM, ST_CHANGE} st_t;

  st_t             st;
  logic [PC_W-1:0] pidx;
  logic            addr_hit;
  logic            want_ddr;
  logic [CNT_W-1:0] cnt;

  wire [CNT_W-1:0] load_cnt = (itc_cycles == '0) ? CNT_W'(1) : itc_cycles;

  assign busy = (st == ST_CHANGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pidx     <= '0;
      addr_hit <= 1'b0;
      want_ddr <= 1'b0;
      cnt      <= '0;
      ddr_sel  <= 1'b0;
    end else begin
      case (st)
        ST_CHANGE: begin
          if (cnt == CNT_W'(1)) begin
            ddr_sel <= want_ddr;
            st      <= ST_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (cmd_we) begin
            st   <= (bus_in == SET_FEAT_OP) ? ST_ADDR : ST_IDLE;
            pidx <= '0;
          end else if (st == ST_ADDR && addr_we) begin
            addr_hit <= (bus_in == IF_FEAT_ADDR);
            st       <= ST_PARAM;
          end else if (st == ST_PARAM && data_we) begin
            if (pidx == '0) want_ddr <= bus_in[0];
            if (pidx == LAST_IDX) begin
              st  <= addr_hit ? ST_CHANGE : ST_IDLE;
              cnt <= load_cnt;
            end else begin
              pidx <= pidx + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ifsel_ctrl_chk.sv
module ifsel_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic data_we,
  input logic ddr_sel,
  input logic busy
);
  p_reset_async_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ddr_sel && !busy));

  p_busy_after_param_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_we));

  p_sel_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(ddr_sel));

  p_sel_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ddr_sel) |-> $fell(busy));
endmodule

bind ifsel_ctrl ifsel_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .data_we(data_we), .ddr_sel(ddr_sel), .busy(busy)
);

// File: tb/ifsel_ctrl_tb.sv
module ifsel_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0, addr_we = 1'b0, data_we = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [CNT_W-1:0] itc_cycles = '0;
  logic ddr_sel, busy;
  int n_run = 0, n_fail = 0;

  ifsel_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we), .data_we(data_we),
    .bus_in(bus_in), .itc_cycles(itc_cycles), .ddr_sel(ddr_sel), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int kind, input logic [7:0] b);
    @(negedge clk);
    cmd_we = (kind == 0); addr_we = (kind == 1); data_we = (kind == 2); bus_in = b;
    @(negedge clk);
    cmd_we = 1'b0; addr_we = 1'b0; data_we = 1'b0;
  endtask

  task automatic set_feature(input logic [7:0] op, input logic [7:0] fa, input logic [7:0] p0);
    drive(0, op);
    drive(1, fa);
    drive(2, p0);
    drive(2, 8'hA5);
    drive(2, 8'h5A);
    drive(2, 8'hFF);
  endtask

  task automatic watch_change(input string req, input int exp_len, input logic old_sel, input logic new_sel);
    int len = 0;
    int bad = 0;
    while (busy && len < 1000) begin
      if (ddr_sel !== old_sel) bad++;
      len++;
      @(negedge clk);
    end
    chk({req, " busy length"}, len, exp_len);
    chk({req, " select held during busy"}, bad, 0);
    chk({req, " select after busy"}, int'(ddr_sel), int'(new_sel));
  endtask

  task automatic quiet(input string req, input logic exp_sel, input int cycles);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy !== 1'b0 || ddr_sel !== exp_sel) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset select", int'(ddr_sel), 0);
    chk("R1 reset busy", int'(busy), 0);
  endtask

  task automatic t_to_ddr();
    itc_cycles = 16'd5;
    set_feature(8'hEF, 8'h10, 8'hFF);
    chk("R4 busy after last param", int'(busy), 1);
    watch_change("R5 R6 to DDR", 5, 1'b0, 1'b1);
  endtask

  task automatic t_to_async();
    itc_cycles = 16'd3;
    set_feature(8'hEF, 8'h10, 8'hFE);
    watch_change("R3 back to async", 3, 1'b1, 1'b0);
  endtask

  task automatic t_bad_addr();
    itc_cycles = 16'd4;
    set_feature(8'hEF, 8'h11, 8'h01);
    quiet("R7 other feature address ignored", 1'b0, 6);
  endtask

  task automatic t_bad_op();
    itc_cycles = 16'd4;
    set_feature(8'h90, 8'h10, 8'h01);
    quiet("R2 other opcode ignored", 1'b0, 6);
  endtask

  task automatic t_ignore_busy();
    itc_cycles = 16'd30;
    set_feature(8'hEF, 8'h10, 8'h01);
    itc_cycles = 16'd2;
    set_feature(8'hEF, 8'h10, 8'h00);
    watch_change("R8 R4 traffic during busy", 18, 1'b0, 1'b1);
    quiet("R8 no second change", 1'b1, 5);
  endtask

  task automatic t_zero_count();
    itc_cycles = 16'd0;
    set_feature(8'hEF, 8'h10, 8'h00);
    watch_change("R9 zero count", 1, 1'b1, 1'b0);
  endtask

  task automatic t_restart();
    itc_cycles = 16'd2;
    drive(0, 8'hEF);
    drive(1, 8'h10);
    drive(2, 8'h01);
    set_feature(8'hEF, 8'h10, 8'h01);
    watch_change("R10 restarted sequence", 2, 1'b0, 1'b1);
  endtask

  task automatic t_reset_mid();
    itc_cycles = 16'd10;
    set_feature(8'hEF, 8'h10, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset aborts busy", int'(busy), 0);
    chk("R1 reset select during change", int'(ddr_sel), 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    quiet("R1 idle after reset", 1'b0, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_to_ddr();
    t_to_async();
    t_bad_addr();
    t_bad_op();
    t_ignore_busy();
    t_zero_count();
    t_restart();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule